// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers up to eighty event lines into five sixteen-bit secondary status registers, each paired with a mask register. The unmasked status bits are reduced into a twelve-bit group summary. A primary mask gates that summary, and the result drives one active-low, level-sensitive interrupt line toward a host. The host reaches every register through a simple single-cycle read/write port. It reads the summary to find the active groups, reads the matching status registers, and then writes the bits it read back to the same status address to acknowledge them.

The event lines of the first four registers are internal sources: a bit latches in any cycle where its line is high. The fifth register holds sixteen general-purpose pin inputs, which are treated as levels and pass through edge detection. The first eleven pins each have a two-bit control register that selects both edges, rising or falling. The remaining five always detect rising edges. A status bit latches whether or not it is masked. Masking only decides whether the bit reaches the summary and the output.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every secondary mask reads 0xFFFF, the primary mask reads 0x0FFF, every status register and the summary read 0, each pin control register reads 0x0001, and irq_n is high.
- R2: For register index r (0 to 3), line evt_in[16*r+b] high at a clock edge sets status bit b of that register. The bit stays set until acknowledged, whether or not it is masked.
- R3: A write to a status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: If an event sets a status bit in the same cycle that a write clears it, the bit remains set.
- R5: Summary bit g is the OR of status & ~mask over its member bits. Membership by register (1-based) and bit: g0 = reg1 bit0; g1 = reg5 bits 0-15; g2 = reg1 bit1; g3 = reg1 bits 2-4; g4 = reg1 bit5; g5 = reg1 bits 6-7; g6 = reg2 bits 0-7; g7 = reg1 bits 8-9; g8 = reg1 bits 10-14; g9 = reg2 bits 8-9; g10 = reg4 bits 0-1; g11 = reg3 bits 0-9 and reg4 bits 2-5. All other bits latch but belong to no group.
- R6: The group g11 (undervoltage) is raised by an unmasked bit in either register 3 or register 4.
- R7: irq_n is low in the cycle after one in which summary & ~primary_mask is nonzero, and high otherwise. A primary mask of all ones keeps it high.
- R8: Pin k (0 to 10, status register 5 bit k) uses control bit 1 as mode and bit 0 as polarity. Mode 1 detects both edges, mode 0 with polarity 1 detects rising edges, and mode 0 with polarity 0 detects falling edges. Edges are judged against the level at the previous clock edge.
- R9: Pins 11 to 15 always detect rising edges. Writes to control addresses above pin 10 are ignored, and those addresses read 0.
- R10: The summary register is read-only, so writes to it change nothing.
- R11: Address map (6-bit): 0x00 summary, 0x01 primary mask, 0x08+i status register i+1, 0x10+i mask register i+1, 0x20+k pin k control. Reads return data combinationally and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 80 | Event lines; bits 64-79 are pin levels |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| irq_n | output | 1 | Active-low level interrupt to the host |

## Verification
The hardest situation to reach is a status bit being acknowledged in the exact cycle its source fires again, because random writes rarely land on a pending bit at that moment. The stimulus therefore drives the event and the matching write-one-to-clear together on purpose. Pin edges just after a control change are also hard to hit, so each edge mode is selected directly and the pin is then toggled in both directions. The undervoltage group is raised from register 4 alone while register 3 stays masked. Long random traffic with sparse events, random mask values and random acknowledgements then checks every register and the output against a bench model.

// File: rtl/irq_agg_pkg.sv
// Package for the interrupt aggregator: group codes, address offsets and the
// mapping from a secondary status bit to its summary group.
// Assumes five 16-bit secondary registers; unmapped bits return GRP_NONE.
package irq_agg_pkg;

    localparam int GROUPS = 12;

    localparam logic [3:0] GRP_NONE = 4'hF;

    // register port offsets (word addresses)
    localparam int A_SUMMARY = 'h00;
    localparam int A_PMASK   = 'h01;
    localparam int A_STATUS  = 'h08;
    localparam int A_MASK    = 'h10;
    localparam int A_PINCFG  = 'h20;

    // Summary group of status bit b in register index r (0-based).
    function automatic logic [3:0] group_of(input int r, input int b);
        logic [3:0] g;
        g = GRP_NONE;
        case (r)
            0: begin
                if (b == 0)       g = 4'd0;
                else if (b == 1)  g = 4'd2;
                else if (b <= 4)  g = 4'd3;
                else if (b == 5)  g = 4'd4;
                else if (b <= 7)  g = 4'd5;
                else if (b <= 9)  g = 4'd7;
                else if (b <= 14) g = 4'd8;
            end
            1: begin
                if (b <= 7)       g = 4'd6;
                else if (b <= 9)  g = 4'd9;
            end
            2: begin
                if (b <= 9)       g = 4'd11;
            end
            3: begin
                if (b <= 1)       g = 4'd10;
                else if (b <= 5)  g = 4'd11;
            end
            4: g = 4'd1;
            default: g = GRP_NONE;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/irq_edge_unit.sv
// Edge detector for the pin sources of the last status register.
// Pins below NCFG follow their mode/polarity control; the rest detect rising
// edges only. Assumes NCFG <= NPIN and levels synchronous to clk.
module irq_edge_unit #(
    parameter int NPIN = 16,
    parameter int NCFG = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] lvl,
    input  logic [NCFG-1:0] cfg_both,
    input  logic [NCFG-1:0] cfg_pol,
    output logic [NPIN-1:0] hit
);

    logic [NPIN-1:0] prev;

    // Remember the level seen at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        if (p < NCFG) begin : g_cfg
            assign hit[p] = cfg_both[p] ? (lvl[p] ^ prev[p])
                          : (cfg_pol[p] ? (lvl[p] & ~prev[p]) : (~lvl[p] & prev[p]));
        end else begin : g_fixed
            assign hit[p] = lvl[p] & ~prev[p];
        end
    end

    // R8: an event is reported only when the level differs from last cycle
    assert_hit_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((hit & ~(lvl ^ $past(lvl))) == '0));

endmodule

// File: rtl/irq_status_bank.sv
// One secondary status register with its mask register.
// Status bits set on set_vec and clear on clr_vec (write-one-to-clear); a
// set wins over a clear in the same cycle. Mask resets to all ones.
module irq_status_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] mask
);

    // Latch events and apply acknowledgements.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // Hold the mask written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '1;
        else if (mask_we) mask <= mask_wdata;
    end

    // R2 and R4: every event bit is visible as set on the next cycle
    assert_event_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status & $past(set_vec)) == $past(set_vec)));

    // R3: a cleared bit with no new event reads back as zero
    assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_vec & ~set_vec)) |=> ((status & $past(clr_vec & ~set_vec)) == '0));

endmodule

// File: rtl/irq_group_reduce.sv
// Reduces the masked secondary status into the summary group vector using
// the package group map. Purely combinational.
module irq_group_reduce
    import irq_agg_pkg::*;
#(
    parameter int NREG = 5,
    parameter int W    = 16,
    parameter int NG   = 12
) (
    input  logic [NREG-1:0][W-1:0] status,
    input  logic [NREG-1:0][W-1:0] mask,
    output logic [NG-1:0]          summary
);

    // OR each unmasked status bit into its group.
    always_comb begin
        summary = '0;
        for (int r = 0; r < NREG; r++) begin
            for (int b = 0; b < W; b++) begin
                logic [3:0] g;
                g = group_of(r, b);
                if (g != GRP_NONE && int'(g) < NG)
                    summary[g] = summary[g] | (status[r][b] & ~mask[r][b]);
            end
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
// Top of the two-level interrupt aggregator. Decodes the register port,
// keeps the pin controls and primary mask, and registers the active-low
// interrupt output. Assumes W >= NG and all addresses fit in AW bits.
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int NREG = 5,
    parameter int W    = 16,
    parameter int NCFG = 11,
    parameter int AW   = 6,
    parameter int NG   = GROUPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG*W-1:0] evt_in,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              irq_n
);

    localparam int PIN_REG = NREG - 1;

    logic [NREG-1:0][W-1:0] status;
    logic [NREG-1:0][W-1:0] mask;
    logic [NG-1:0]          summary;
    logic [NG-1:0]          pmask;
    logic [NCFG-1:0]        cfg_both;
    logic [NCFG-1:0]        cfg_pol;
    logic [W-1:0]           pin_hit;

    irq_edge_unit #(.NPIN(W), .NCFG(NCFG)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (evt_in[PIN_REG*W +: W]),
        .cfg_both (cfg_both),
        .cfg_pol  (cfg_pol),
        .hit      (pin_hit)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_bank
        logic [W-1:0] set_v;
        logic         stat_wr;
        logic         mask_wr;
        if (r == PIN_REG) begin : g_pins
            assign set_v = pin_hit;
        end else begin : g_int
            assign set_v = evt_in[r*W +: W];
        end
        assign stat_wr = reg_we && (int'(reg_addr) == A_STATUS + r);
        assign mask_wr = reg_we && (int'(reg_addr) == A_MASK + r);
        irq_status_bank #(.W(W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_vec    (set_v),
            .clr_vec    (stat_wr ? reg_wdata : '0),
            .mask_we    (mask_wr),
            .mask_wdata (reg_wdata),
            .status     (status[r]),
            .mask       (mask[r])
        );
    end

    irq_group_reduce #(.NREG(NREG), .W(W), .NG(NG)) u_reduce (
        .status  (status),
        .mask    (mask),
        .summary (summary)
    );

    // Primary mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pmask <= '1;
        else if (reg_we && int'(reg_addr) == A_PMASK)
            pmask <= reg_wdata[NG-1:0];
    end

    // Pin edge controls; reset selects rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_both <= '0;
            cfg_pol  <= '1;
        end else begin
            for (int c = 0; c < NCFG; c++) begin
                if (reg_we && int'(reg_addr) == A_PINCFG + c) begin
                    cfg_both[c] <= reg_wdata[1];
                    cfg_pol[c]  <= reg_wdata[0];
                end
            end
        end
    end

    // Registered active-low interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= ~(|(summary & ~pmask));
    end

    // Combinational read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == A_SUMMARY) reg_rdata[NG-1:0] = summary;
        if (int'(reg_addr) == A_PMASK)   reg_rdata[NG-1:0] = pmask;
        for (int r = 0; r < NREG; r++) begin
            if (int'(reg_addr) == A_STATUS + r) reg_rdata = status[r];
            if (int'(reg_addr) == A_MASK + r)   reg_rdata = mask[r];
        end
        for (int c = 0; c < NCFG; c++) begin
            if (int'(reg_addr) == A_PINCFG + c) reg_rdata[1:0] = {cfg_both[c], cfg_pol[c]};
        end
    end

    // R1: reset leaves the output idle and every group gated
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_n && (&pmask)));

    // R7: an all-ones primary mask keeps the output high
    assert_pmask_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (&pmask) |=> irq_n);

    // R7: with no active group the output is high next cycle
    assert_quiet_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (summary == '0) |=> irq_n);

endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt_int = '0;
    logic [15:0] pin_lvl = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_n;
    logic [79:0] evt_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    assign evt_in = {pin_lvl, evt_int};

    always #5 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    // bench model built from the requirements
    logic [15:0] m_st [5];
    logic [15:0] m_mk [5];
    logic [11:0] m_pm;
    logic [10:0] m_both, m_pol;
    logic [15:0] m_prev;
    logic        m_irq;

    function automatic int bgroup(int r, int b);
        int k = r * 16 + b;
        if (r == 4) return 1;
        case (k) inside
            0:        return 0;
            1:        return 2;
            [2:4]:    return 3;
            5:        return 4;
            [6:7]:    return 5;
            [8:9]:    return 7;
            [10:14]:  return 8;
            [16:23]:  return 6;
            [24:25]:  return 9;
            [32:41]:  return 11;
            [48:49]:  return 10;
            [50:53]:  return 11;
            default:  return -1;
        endcase
    endfunction

    function automatic logic [11:0] m_summary();
        logic [11:0] s = '0;
        for (int r = 0; r < 5; r++)
            for (int b = 0; b < 16; b++)
                if (bgroup(r, b) >= 0 && m_st[r][b] && !m_mk[r][b]) s[bgroup(r, b)] = 1'b1;
        return s;
    endfunction

    function automatic logic [15:0] m_read(logic [5:0] a);
        if (a == 6'h00) return {4'b0, m_summary()};
        if (a == 6'h01) return {4'b0, m_pm};
        if (a >= 6'h08 && a <= 6'h0C) return m_st[a - 6'h08];
        if (a >= 6'h10 && a <= 6'h14) return m_mk[a - 6'h10];
        if (a >= 6'h20 && a <= 6'h2A) return {14'b0, m_both[a - 6'h20], m_pol[a - 6'h20]};
        return 16'h0000;
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [5:0] a, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, m_read(a));
    endtask

    task automatic model_reset();
        for (int r = 0; r < 5; r++) begin m_st[r] = '0; m_mk[r] = 16'hFFFF; end
        m_pm = 12'hFFF; m_both = '0; m_pol = '1; m_prev = '0; m_irq = 1'b1;
    endtask

    // one clock: predict, advance, compare the output
    task automatic tick(string tag);
        logic [15:0] hits;
        logic [15:0] nst [5];
        logic        nirq;
        for (int p = 0; p < 16; p++) begin
            logic rise, fall;
            rise = pin_lvl[p] & ~m_prev[p];
            fall = ~pin_lvl[p] & m_prev[p];
            if (p < 11) hits[p] = m_both[p] ? (rise | fall) : (m_pol[p] ? rise : fall);
            else        hits[p] = rise;
        end
        nirq = ~(|(m_summary() & ~m_pm));
        for (int r = 0; r < 5; r++) begin
            logic [15:0] clr, set;
            clr = (reg_we && reg_addr == 6'(8 + r)) ? reg_wdata : 16'h0;
            set = (r < 4) ? evt_int[r*16 +: 16] : hits;
            nst[r] = (m_st[r] & ~clr) | set;
        end
        @(posedge clk);
        for (int r = 0; r < 5; r++) begin
            m_st[r] = nst[r];
            if (reg_we && reg_addr == 6'(16 + r)) m_mk[r] = reg_wdata;
        end
        if (reg_we && reg_addr == 6'h01) m_pm = reg_wdata[11:0];
        if (reg_we && reg_addr >= 6'h20 && reg_addr <= 6'h2A) begin
            m_both[reg_addr - 6'h20] = reg_wdata[1];
            m_pol[reg_addr - 6'h20]  = reg_wdata[0];
        end
        m_prev = pin_lvl;
        m_irq = nirq;
        @(negedge clk);
        chk(tag, {15'b0, irq_n}, {15'b0, m_irq});
        reg_we = 1'b0;
        evt_int = '0;
    endtask

    task automatic wr(logic [5:0] a, logic [15:0] d, string tag);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk("R1 irq_n", {15'b0, irq_n}, 16'h0001);
        for (int r = 0; r < 5; r++) begin
            rd(6'(8 + r), "R1 status");
            rd(6'(16 + r), "R1 mask");
        end
        rd(6'h01, "R1 pmask");
        rd(6'h00, "R1 summary");
        rd(6'h20, "R1 pincfg");
        reg_addr = 6'h10; #1; chk("R1 mask literal", reg_rdata, 16'hFFFF);

        // R2 masked event still latches
        evt_int[0] = 1'b1; tick("R2 masked");
        reg_addr = 6'h08; #1; chk("R2 latch", reg_rdata, 16'h0001);
        tick("R2 hold");
        rd(6'h08, "R2 hold read");

        // R5/R7 unmask path
        wr(6'h01, 16'h0000, "R7 pmask");
        wr(6'h10, 16'hFFFE, "R5 mask1");
        tick("R7 assert");
        chk("R7 low", {15'b0, irq_n}, 16'h0000);
        reg_addr = 6'h00; #1; chk("R5 summary g0", reg_rdata, 16'h0001);

        // R3 write zero keeps, write one clears
        wr(6'h08, 16'h0000, "R3 zero write");
        rd(6'h08, "R3 kept");
        wr(6'h08, 16'h0001, "R3 clear");
        reg_addr = 6'h08; #1; chk("R3 cleared", reg_rdata, 16'h0000);
        tick("R7 release");
        chk("R7 high", {15'b0, irq_n}, 16'h0001);

        // R10 summary read-only
        wr(6'h00, 16'hFFFF, "R10 write");
        rd(6'h00, "R10 summary");
        rd(6'h01, "R10 pmask intact");

        // R4 event wins over same-cycle clear
        evt_int[16+3] = 1'b1; tick("R4 set");
        evt_int[16+3] = 1'b1; wr(6'h09, 16'h0008, "R4 race");
        reg_addr = 6'h09; #1; chk("R4 stays", reg_rdata, 16'h0008);
        wr(6'h09, 16'hFFFF, "R4 cleanup");

        // R6 undervoltage from register 4 alone
        wr(6'h13, 16'hFFFB, "R6 mask4");
        evt_int[48+2] = 1'b1; tick("R6 event");
        reg_addr = 6'h00; #1; chk("R6 g11", reg_rdata, 16'h0800);
        tick("R6 irq");
        chk("R6 irq low", {15'b0, irq_n}, 16'h0000);
        wr(6'h0B, 16'hFFFF, "R6 clear");
        tick("R6 settle");

        // R8 pin 0 edge modes
        wr(6'h14, 16'h0000, "R8 mask5");
        wr(6'h20, 16'h0000, "R8 falling");
        pin_lvl[0] = 1'b1; tick("R8 rise ignored");
        reg_addr = 6'h0C; #1; chk("R8 no rise", reg_rdata, 16'h0000);
        pin_lvl[0] = 1'b0; tick("R8 fall");
        reg_addr = 6'h0C; #1; chk("R8 fall seen", reg_rdata, 16'h0001);
        wr(6'h0C, 16'hFFFF, "R8 ack");
        wr(6'h20, 16'h0002, "R8 both");
        pin_lvl[0] = 1'b1; tick("R8 both rise");
        rd(6'h0C, "R8 both rise read");
        wr(6'h0C, 16'hFFFF, "R8 ack2");
        pin_lvl[0] = 1'b0; tick("R8 both fall");
        reg_addr = 6'h0C; #1; chk("R8 both fall", reg_rdata, 16'h0001);
        wr(6'h0C, 16'hFFFF, "R8 ack3");
        wr(6'h20, 16'h0001, "R8 rising");
        pin_lvl[0] = 1'b1; tick("R8 rise");
        rd(6'h0C, "R8 rise read");
        pin_lvl[0] = 1'b0; wr(6'h0C, 16'hFFFF, "R8 ack4");
        tick("R8 fall ignored");
        reg_addr = 6'h0C; #1; chk("R8 no fall", reg_rdata, 16'h0000);

        // R9 fixed rising pins and ignored control
        wr(6'h2B, 16'h0000, "R9 write ignored");
        reg_addr = 6'h2B; #1; chk("R9 read zero", reg_rdata, 16'h0000);
        pin_lvl[11] = 1'b1; tick("R9 rise");
        reg_addr = 6'h0C; #1; chk("R9 rise seen", reg_rdata, 16'h0800);
        wr(6'h0C, 16'hFFFF, "R9 ack");
        pin_lvl[11] = 1'b0; tick("R9 fall");
        reg_addr = 6'h0C; #1; chk("R9 no fall", reg_rdata, 16'h0000);

        // R11 unmapped
        rd(6'h3F, "R11 unmapped");
        rd(6'h05, "R11 gap");

        // random traffic covering R2 R3 R5 R7 R8
        for (int i = 0; i < 4000; i++) begin
            evt_int[31:0]  = $urandom & $urandom & $urandom & $urandom;
            evt_int[63:32] = $urandom & $urandom & $urandom & $urandom;
            if ($urandom_range(0, 3) == 0) pin_lvl ^= 16'(1 << $urandom_range(0, 15));
            if ($urandom_range(0, 2) == 0) begin
                int sel;
                sel = $urandom_range(0, 23);
                reg_we = 1'b1;
                if (sel < 2)       reg_addr = 6'(sel);
                else if (sel < 7)  reg_addr = 6'(8 + sel - 2);
                else if (sel < 12) reg_addr = 6'(16 + sel - 7);
                else               reg_addr = 6'(32 + sel - 12);
                reg_wdata = 16'($urandom);
            end
            tick("R7 random irq");
            if (i % 8 == 0) begin
                for (int r = 0; r < 5; r++) begin
                    rd(6'(8 + r), "R2 R3 random status");
                    rd(6'(16 + r), "R5 random mask");
                end
                rd(6'h00, "R5 random summary");
                rd(6'(32 + $urandom_range(0, 11)), "R8 random cfg");
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule